// File: doc/BRIEF.md
# Multiplexed LCD Waveform Sequencer

This block produces the common and segment drive codes for a time-multiplexed liquid-crystal panel with up to four common lines and 24 segment lines. It runs from the 32.768 kHz low-speed clock. Each frame is split into equal time slots, one for each active common. In each slot one common is selected, and every segment shows the pixel that sits where it crosses that common. On every output the block emits a 2-bit level code: 0 = VSS, 1 = VL1, 2 = VL2, 3 = VL3. An external analog bias switch turns these codes into voltages.

The polarity of the drive flips on alternate frames, so that no pixel sees a net DC voltage. The multiplex ratio can be set from one to four commons. The bias can be set to one third or one half. One of four frame rates can be chosen. The drive mode can stop the panel, show the display data, or force every segment on or off.

Top module: `lcd_wave_seq`

## Requirements
- R1: While reset is asserted, the block holds slot 0 and positive polarity. With `mode_i` = 0 every output code is 0. With `mode_i` = 1, common 0 reads 3 and the other commons read 1.
- R2: `mode_i` = 0 (stop) drives code 0 on every common and segment output and clears the timing state. On leaving stop, the sequence restarts at slot 0 with positive polarity.
- R3: Slot length L = frame_div / (`duty_i`+1) clock cycles, using integer division. After t clock edges in a running mode, the selected common is (t / L) mod (`duty_i`+1).
- R4: Polarity is positive for even values of t / (L·(`duty_i`+1)) and inverted for odd values.
- R5: At 1/3 bias (`bias3_i` = 1) and positive polarity, the levels are as follows. The selected common drives 3 and the other commons drive 1. An on segment drives 0 and an off segment drives 2.
- R6: At inverted polarity, every code given in R5 is replaced by 3 minus that code.
- R7: At 1/2 bias (`bias3_i` = 0), any code that would be 2 is emitted as 1, so no output ever carries code 2.
- R8: Commons with an index above `duty_i` are never selected and carry the non-selected level. Pixel bits for those commons have no effect.
- R9: `mode_i` = 2 treats every pixel as on, and `mode_i` = 3 treats every pixel as off. In both modes `seg_data_i` is ignored.
- R10: `rate_i` values 0, 1, 2 and 3 select a frame_div of 512, 448, 384 and 320 cycles. This gives frame rates of about 64, 73, 85 and 102 Hz.
- R11: Bit s·4+c of `seg_data_i` is the pixel at segment s and common c, where 1 means on. `mode_i` = 1 shows this data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz low-speed clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 0 stop, 1 display, 2 all on, 3 all off |
| duty_i | input | 2 | Number of active commons minus one |
| bias3_i | input | 1 | 1 selects 1/3 bias, 0 selects 1/2 bias |
| rate_i | input | 2 | Frame divider select |
| seg_data_i | input | 96 | Pixel array, bit s·4+c |
| com_lvl_o | output | 8 | Level code for each common, 2 bits per common |
| seg_lvl_o | output | 48 | Level code for each segment, 2 bits per segment |

## Verification
The assertions assume that `mode_i`, `bias3_i`, `duty_i` and `rate_i` change only between clock edges, and that `duty_i` and `rate_i` are changed only while the block is in stop mode. The bench keeps to this rule: it loads each new configuration while `mode_i` is 0 and then switches to a running mode. Inside each run it compares every output against a model built from the slot arithmetic of R3 and R4.

// File: rtl/lcd_wave_pkg.sv
package lcd_wave_pkg;
  typedef enum logic [1:0] {
    LVL_VSS = 2'd0,
    LVL_VL1 = 2'd1,
    LVL_VL2 = 2'd2,
    LVL_VL3 = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    MODE_STOP    = 2'd0,
    MODE_SHOW    = 2'd1,
    MODE_ALL_ON  = 2'd2,
    MODE_ALL_OFF = 2'd3
  } mode_e;

  // mirror on inverted frame, merge the two mid levels at half bias
  function automatic logic [1:0] fold_lvl(logic [1:0] code, logic inv, logic bias3);
    logic [1:0] v;
    v = inv ? ~code : code;
    if (!bias3 && v == LVL_VL2) v = LVL_VL1;
    return v;
  endfunction
endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
  parameter int NUM_COM = 4,
  parameter int DIV0    = 512,
  parameter int DIV1    = 448,
  parameter int DIV2    = 384,
  parameter int DIV3    = 320,
  localparam int SLOT_W = (NUM_COM > 1) ? $clog2(NUM_COM) : 1,
  localparam int CNT_W  = $clog2(DIV0 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [1:0]        rate_i,
  input  logic [SLOT_W-1:0] duty_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              inv_o
);
  logic [CNT_W-1:0] base_div, slot_len, duty_ext, cnt_q;
  logic [SLOT_W-1:0] slot_q;
  logic inv_q;

  always_comb begin
    unique case (rate_i)
      2'd0:    base_div = CNT_W'(DIV0);
      2'd1:    base_div = CNT_W'(DIV1);
      2'd2:    base_div = CNT_W'(DIV2);
      default: base_div = CNT_W'(DIV3);
    endcase
    duty_ext = CNT_W'(duty_i);
    slot_len = base_div / (duty_ext + CNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      slot_q <= '0;
      inv_q  <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      slot_q <= '0;
      inv_q  <= 1'b0;
    end else if (cnt_q >= slot_len - CNT_W'(1)) begin
      cnt_q <= '0;
      if (slot_q >= duty_i) begin
        slot_q <= '0;
        inv_q  <= ~inv_q;
      end else begin
        slot_q <= slot_q + SLOT_W'(1);
      end
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign slot_o = slot_q;
  assign inv_o  = inv_q;
endmodule

// File: rtl/lcd_com_drv.sv
module lcd_com_drv
  import lcd_wave_pkg::*;
#(
  parameter int NUM_COM = 4,
  localparam int SLOT_W = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic                 run_i,
  input  logic                 bias3_i,
  input  logic                 inv_i,
  input  logic [SLOT_W-1:0]    slot_i,
  output logic [2*NUM_COM-1:0] com_lvl_o
);
  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    logic [1:0] raw;
    assign raw = (slot_i == SLOT_W'(c)) ? LVL_VL3 : LVL_VL1;
    assign com_lvl_o[2*c +: 2] = run_i ? fold_lvl(raw, inv_i, bias3_i) : LVL_VSS;
  end
endmodule

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv
  import lcd_wave_pkg::*;
#(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 24,
  localparam int SLOT_W = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic [1:0]               mode_i,
  input  logic                     bias3_i,
  input  logic                     inv_i,
  input  logic [SLOT_W-1:0]        slot_i,
  input  logic [NUM_SEG*NUM_COM-1:0] seg_data_i,
  output logic [2*NUM_SEG-1:0]     seg_lvl_o
);
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [NUM_COM-1:0] pix;
    logic on, run;
    logic [1:0] raw;
    assign pix = seg_data_i[s*NUM_COM +: NUM_COM];
    assign run = (mode_i != MODE_STOP);
    always_comb begin
      unique case (mode_i)
        MODE_ALL_ON:  on = 1'b1;
        MODE_ALL_OFF: on = 1'b0;
        default:      on = pix[slot_i];
      endcase
    end
    assign raw = on ? LVL_VSS : LVL_VL2;
    assign seg_lvl_o[2*s +: 2] = run ? fold_lvl(raw, inv_i, bias3_i) : LVL_VSS;
  end
endmodule

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq
  import lcd_wave_pkg::*;
#(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 24,
  localparam int SLOT_W = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0]                 mode_i,
  input  logic [SLOT_W-1:0]          duty_i,
  input  logic                       bias3_i,
  input  logic [1:0]                 rate_i,
  input  logic [NUM_SEG*NUM_COM-1:0] seg_data_i,
  output logic [2*NUM_COM-1:0]       com_lvl_o,
  output logic [2*NUM_SEG-1:0]       seg_lvl_o
);
  logic run;
  logic inv;
  logic [SLOT_W-1:0] slot;

  assign run = (mode_i != MODE_STOP);

  lcd_frame_timer #(.NUM_COM(NUM_COM)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .rate_i(rate_i),
    .duty_i(duty_i),
    .slot_o(slot),
    .inv_o (inv)
  );

  lcd_com_drv #(.NUM_COM(NUM_COM)) u_com (
    .run_i    (run),
    .bias3_i  (bias3_i),
    .inv_i    (inv),
    .slot_i   (slot),
    .com_lvl_o(com_lvl_o)
  );

  lcd_seg_drv #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_seg (
    .mode_i    (mode_i),
    .bias3_i   (bias3_i),
    .inv_i     (inv),
    .slot_i    (slot),
    .seg_data_i(seg_data_i),
    .seg_lvl_o (seg_lvl_o)
  );
endmodule

// File: rtl/lcd_wave_seq_chk.sv
module lcd_wave_seq_chk #(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 24
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [1:0]           mode_i,
  input logic                 bias3_i,
  input logic [2*NUM_COM-1:0] com_lvl_o,
  input logic [2*NUM_SEG-1:0] seg_lvl_o
);
  logic [NUM_COM-1:0] sel_v;
  logic [1:0] sel_code;
  logic [NUM_SEG-1:0] mirror_ok, off_ok;
  logic any_two;

  always_comb begin
    sel_code = 2'd0;
    any_two  = 1'b0;
    for (int c = 0; c < NUM_COM; c++) begin
      sel_v[c] = (com_lvl_o[2*c +: 2] == 2'd3) || (com_lvl_o[2*c +: 2] == 2'd0);
      if (sel_v[c]) sel_code = com_lvl_o[2*c +: 2];
      if (com_lvl_o[2*c +: 2] == 2'd2) any_two = 1'b1;
    end
    for (int s = 0; s < NUM_SEG; s++) begin
      mirror_ok[s] = (seg_lvl_o[2*s +: 2] == ~sel_code);
      off_ok[s]    = (seg_lvl_o[2*s +: 2] == 2'd1) || (seg_lvl_o[2*s +: 2] == 2'd2);
      if (seg_lvl_o[2*s +: 2] == 2'd2) any_two = 1'b1;
    end
  end

  assert_stop_vss_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0) |-> (com_lvl_o == '0 && seg_lvl_o == '0));

  assert_one_select_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd0) |-> ($countones(sel_v) == 1));

  assert_half_bias_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bias3_i |-> !any_two);

  assert_all_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2) |-> (&mirror_ok));

  assert_all_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |-> (&off_ok));
endmodule

bind lcd_wave_seq lcd_wave_seq_chk #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .bias3_i  (bias3_i),
  .com_lvl_o(com_lvl_o),
  .seg_lvl_o(seg_lvl_o)
);

// File: tb/lcd_wave_seq_bench.sv
module lcd_wave_seq_bench;
  localparam int NC = 4;
  localparam int NS = 24;
  localparam int DW = NC * NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [1:0] duty = 2'd3;
  logic bias3 = 1'b1;
  logic [1:0] rate = 2'd0;
  logic [DW-1:0] data = '0;
  logic [2*NC-1:0] com_lvl;
  logic [2*NS-1:0] seg_lvl;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lcd_wave_seq #(.NUM_COM(NC), .NUM_SEG(NS)) u_lcd_wave_seq (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .duty_i(duty),
    .bias3_i(bias3), .rate_i(rate), .seg_data_i(data),
    .com_lvl_o(com_lvl), .seg_lvl_o(seg_lvl)
  );

  function automatic int base_div(int r);
    case (r)
      0: return 512;
      1: return 448;
      2: return 384;
      default: return 320;
    endcase
  endfunction

  function automatic logic [1:0] bfold(int code, int pol, bit b3);
    int v;
    v = pol ? 3 - code : code;
    if (!b3 && v == 2) v = 1;
    return 2'(v);
  endfunction

  function automatic logic [2*NC-1:0] exp_com(int t, int r, int d, bit b3, int m);
    logic [2*NC-1:0] res;
    int n, len, slot, pol;
    res = '0;
    if (m == 0) return res;
    n = d + 1; len = base_div(r) / n;
    slot = (t / len) % n; pol = (t / (len * n)) % 2;
    for (int c = 0; c < NC; c++) res[2*c +: 2] = bfold((c == slot) ? 3 : 1, pol, b3);
    return res;
  endfunction

  function automatic logic [2*NS-1:0] exp_seg(int t, int r, int d, bit b3, int m,
                                               logic [DW-1:0] px);
    logic [2*NS-1:0] res;
    int n, len, slot, pol;
    bit on;
    res = '0;
    if (m == 0) return res;
    n = d + 1; len = base_div(r) / n;
    slot = (t / len) % n; pol = (t / (len * n)) % 2;
    for (int s = 0; s < NS; s++) begin
      on = (m == 2) ? 1'b1 : (m == 3) ? 1'b0 : px[s*NC + slot];
      res[2*s +: 2] = bfold(on ? 0 : 2, pol, b3);
    end
    return res;
  endfunction

  task automatic check_now(string tag, logic [2*NC-1:0] ec, logic [2*NS-1:0] es);
    checks++;
    if (com_lvl !== ec || seg_lvl !== es) begin
      fails++;
      $display("FAIL %s com=%h seg=%h expected com=%h seg=%h", tag, com_lvl, seg_lvl, ec, es);
    end
  endtask

  // load config in stop, then run ncyc edges comparing every cycle
  task automatic run_cfg(int r, int d, bit b3, int m, logic [DW-1:0] px, int ncyc, string tag);
    @(negedge clk);
    mode = 2'd0; rate = 2'(r); duty = 2'(d); bias3 = b3; data = px;
    @(posedge clk);
    @(negedge clk);
    check_now("R2", '0, '0);
    mode = 2'(m);
    #1;
    check_now(tag, exp_com(0, r, d, b3, m), exp_seg(0, r, d, b3, m, px));
    for (int t = 1; t <= ncyc; t++) begin
      @(posedge clk);
      @(negedge clk);
      check_now(tag, exp_com(t, r, d, b3, m), exp_seg(t, r, d, b3, m, px));
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    int r, d, m, frame;
    bit b3;
    logic [DW-1:0] px;
    seed = $urandom(777);
    data = {$urandom, $urandom, $urandom};
    // R1: in reset
    #12;
    check_now("R1", '0, '0);
    mode = 2'd1;
    #1;
    check_now("R1", exp_com(0, 0, 3, 1, 1), exp_seg(0, 0, 3, 1, 1, data));
    mode = 2'd0;
    @(negedge clk);
    rst_n = 1'b1;

    // R10: frame lengths per rate, full two frames
    for (int k = 0; k < 4; k++)
      run_cfg(k, 3, 1, 1, {$urandom, $urandom, $urandom}, 2 * base_div(k) + 3, "R10");
    // R11: single pixel
    px = '0; px[5*NC + 2] = 1'b1;
    run_cfg(3, 3, 1, 1, px, 700, "R11");
    // R8: pixels only on unused commons
    px = '0;
    for (int s = 0; s < NS; s++) px[s*NC + 2 +: 2] = 2'b11;
    run_cfg(1, 1, 1, 1, px, 2 * 448 + 5, "R8");
    // R3 R4: single common, polarity per slot; three commons truncated slots
    run_cfg(2, 0, 1, 1, {$urandom, $urandom, $urandom}, 800, "R3 R4");
    run_cfg(3, 2, 1, 1, {$urandom, $urandom, $urandom}, 2 * 318 + 4, "R3 R4 R6");
    // R7 half bias, R9 forced modes
    run_cfg(0, 3, 0, 1, {$urandom, $urandom, $urandom}, 1030, "R7");
    run_cfg(1, 2, 1, 2, {$urandom, $urandom, $urandom}, 900, "R9");
    run_cfg(2, 1, 0, 3, {$urandom, $urandom, $urandom}, 800, "R9");
    // R2: stop mid frame, hold zero, restart from slot 0
    run_cfg(0, 3, 1, 1, {$urandom, $urandom, $urandom}, 300, "R5");
    @(negedge clk);
    mode = 2'd0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      @(negedge clk);
      check_now("R2", '0, '0);
    end
    run_cfg(0, 3, 1, 1, data, 150, "R2");

    // random configurations
    for (int i = 0; i < 30; i++) begin
      r = $urandom_range(0, 3);
      d = $urandom_range(0, 3);
      b3 = 1'($urandom_range(0, 1));
      m = $urandom_range(1, 3);
      frame = (base_div(r) / (d + 1)) * (d + 1);
      run_cfg(r, d, b3, m, {$urandom, $urandom, $urandom}, 2 * frame + 7,
              (m != 1) ? "R9" : (b3 ? "R5 R6" : "R7"));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule